// File: doc/BRIEF.md
# Analog/Digital PLL Switchover Sequencer

This block decides which clock-recovery loop an optical-disc data path uses. The wide-capture analog loop is used while the pickup is moving. The noise-tolerant digital loop is used once playback has settled. The system controller reports its servo events to the sequencer as single-cycle strobes: an access begins, the pickup is kicked or jumps tracks, a subcode read completes with a pass or fail result, and the access is judged finished. The sequencer also watches the level of the constant-linear-velocity sync flag and a level that says the player is in play.

The sequencer accepts these events only in a fixed order: kick, then a good subcode read, then the access-end judgement, then the sync flag seen high. When that order completes, it switches the select output to the digital loop. In the same cycle it emits a one-cycle register write that carries the digital loop's mode word. That word is built from three configuration levels: double speed, fine resolution and fast oscillator. An access start, a failed read during play, a new kick, or a timeout while waiting for sync each sends the block back to the analog loop.

Top module: `pll_switch_seq`

## Requirements
- R1: After reset the analog loop is selected (`sel_digital_o`=0), `state_o`=0 (idle), `wr_strobe_o`=0 and `cfg_err_o`=0.
- R2: An `access_start_i` pulse in any state has the highest priority. After the next clock edge the block is in state 1 (await kick) with the analog loop selected.
- R3: The sequence advances only in the order kick (1→2), good read (`q_valid_i`=1 with `q_ok_i`=1, 2→3), access end (3→4), sync high (4→5). An event that arrives in any other state has no effect on `state_o`.
- R4: When `sync_flag_i` is high in state 4, the next clock edge moves the block to state 5. In the same cycle `sel_digital_o` rises and `wr_strobe_o` is high for exactly one cycle with `wr_addr_o`=0x4E.
- R5: The mode word `wr_data_o` carries bit 10 = double speed, bit 7 = fine (1/16) resolution and bit 6 = fast oscillator. Every other bit is 0.
- R6: A fast-oscillator request without double speed is written with bit 6 cleared. The first clock edge that sees this combination also sets `cfg_err_o`, which then stays set until reset.
- R7: A failed read in state 2 returns the block to state 1. In state 5 with `play_i`=1, a failed read returns the block to state 1 with the analog loop selected. With `play_i`=0 the failed read is ignored.
- R8: A kick in state 3, 4 or 5 returns the block to state 2 with the analog loop selected. From there the digital loop can be re-engaged only after a new good read.
- R9: With `sync_timeout_i`=T>0 and sync held low, the block spends exactly T cycles in state 4 and then goes to state 1. T=0 disables the timeout.
- R10: State codes are 0 idle, 1 await kick, 2 await read, 3 await access end, 4 await sync, 5 digital. `sel_digital_o` is 1 only in state 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_start_i | input | 1 | Access operation begins (strobe) |
| kick_i | input | 1 | Kick or track jump performed (strobe) |
| q_valid_i | input | 1 | Subcode read completed (strobe) |
| q_ok_i | input | 1 | Read result, 1 = good, qualified by q_valid_i |
| access_end_i | input | 1 | Access judged finished (strobe) |
| sync_flag_i | input | 1 | CLV sync established (level) |
| play_i | input | 1 | Player is in play (level) |
| cfg_double_i | input | 1 | Double-speed operation |
| cfg_fine_i | input | 1 | Fine (1/16) resolution |
| cfg_fast_vco_i | input | 1 | Fast oscillator request |
| sync_timeout_i | input | 16 | Cycles allowed in await-sync, 0 = never |
| sel_digital_o | output | 1 | 1 = digital loop selected |
| wr_strobe_o | output | 1 | Mode register write, one cycle |
| wr_addr_o | output | 8 | Mode register address |
| wr_data_o | output | 16 | Mode word |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |
| state_o | output | 3 | Current state code |

## Verification
The assertions check several properties on every cycle. The write strobe is one cycle wide. Every rise of the digital select comes with the strobe and follows a cycle in which sync was high. An access start always leaves the analog loop selected. A written word never carries the fast oscillator without double speed. The error flag never clears. Only the bench scenarios can show the rest: the full event ordering, the exact mode word for every configuration, the timeout length for each setting, and the play-dependent handling of failed reads.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_KICK = 3'd1,
    ST_WAIT_Q    = 3'd2,
    ST_WAIT_END  = 3'd3,
    ST_WAIT_SYNC = 3'd4,
    ST_DIGITAL   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       access_start,
  input  logic       kick,
  input  logic       q_valid,
  input  logic       q_ok,
  input  logic       access_end,
  input  logic       sync_flag,
  input  logic       play,
  input  logic       expire,
  output seq_state_t state,
  output logic       engage
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (access_start) begin
      state_d = ST_WAIT_KICK;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_WAIT_KICK: if (kick) state_d = ST_WAIT_Q;
        ST_WAIT_Q: begin
          if (kick)         state_d = ST_WAIT_Q;
          else if (q_valid) state_d = q_ok ? ST_WAIT_END : ST_WAIT_KICK;
        end
        ST_WAIT_END: begin
          if (kick)            state_d = ST_WAIT_Q;
          else if (access_end) state_d = ST_WAIT_SYNC;
        end
        ST_WAIT_SYNC: begin
          if (kick)           state_d = ST_WAIT_Q;
          else if (sync_flag) state_d = ST_DIGITAL;
          else if (expire)    state_d = ST_WAIT_KICK;
        end
        ST_DIGITAL: begin
          if (kick)                            state_d = ST_WAIT_Q;
          else if (play && q_valid && !q_ok)   state_d = ST_WAIT_KICK;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state  = state_q;
  assign engage = (state_q == ST_WAIT_SYNC) && (state_d == ST_DIGITAL);
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q;
  logic             cnt_en;

  assign cnt_en = run || (cnt_q != '0);
  assign expire = run && (limit != '0) && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      if (!run || expire) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pll_seq_word.sv
module pll_seq_word #(
  parameter int DATA_W   = 16,
  parameter int FREQ_BIT = 10,
  parameter int RES_BIT  = 7,
  parameter int VCO_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              double_speed,
  input  logic              fine_res,
  input  logic              fast_vco,
  output logic [DATA_W-1:0] word,
  output logic              err
);
  logic illegal;
  logic err_q;

  assign illegal = fast_vco && !double_speed;

  always_comb begin
    word           = '0;
    word[FREQ_BIT] = double_speed;
    word[RES_BIT]  = fine_res;
    word[VCO_BIT]  = fast_vco && double_speed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (illegal) err_q <= 1'b1;
  end

  assign err = err_q;
endmodule

// File: rtl/pll_switch_seq.sv
module pll_switch_seq
  import pll_seq_pkg::*;
#(
  parameter int          TMO_W     = 16,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 16,
  parameter logic [7:0]  MODE_ADDR = 8'h4E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_start_i,
  input  logic              kick_i,
  input  logic              q_valid_i,
  input  logic              q_ok_i,
  input  logic              access_end_i,
  input  logic              sync_flag_i,
  input  logic              play_i,
  input  logic              cfg_double_i,
  input  logic              cfg_fine_i,
  input  logic              cfg_fast_vco_i,
  input  logic [TMO_W-1:0]  sync_timeout_i,
  output logic              sel_digital_o,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              cfg_err_o,
  output logic [2:0]        state_o
);
  seq_state_t        state;
  logic              engage, expire;
  logic [DATA_W-1:0] word;
  logic              wr_q;
  logic [DATA_W-1:0] data_q;

  pll_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n),
    .access_start(access_start_i), .kick(kick_i),
    .q_valid(q_valid_i), .q_ok(q_ok_i),
    .access_end(access_end_i), .sync_flag(sync_flag_i),
    .play(play_i), .expire(expire),
    .state(state), .engage(engage)
  );

  pll_seq_timer #(.TMO_W(TMO_W)) tmr_i (
    .clk(clk), .rst_n(rst_n),
    .run(state == ST_WAIT_SYNC),
    .limit(sync_timeout_i),
    .expire(expire)
  );

  pll_seq_word #(.DATA_W(DATA_W)) word_i (
    .clk(clk), .rst_n(rst_n),
    .double_speed(cfg_double_i), .fine_res(cfg_fine_i),
    .fast_vco(cfg_fast_vco_i),
    .word(word), .err(cfg_err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= engage;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (engage) data_q <= word;
  end

  assign sel_digital_o = (state == ST_DIGITAL);
  assign wr_strobe_o   = wr_q;
  assign wr_addr_o     = ADDR_W'(MODE_ADDR);
  assign wr_data_o     = data_q;
  assign state_o       = state;
endmodule

// File: rtl/pll_switch_seq_chk.sv
module pll_switch_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              access_start_i,
  input logic              q_valid_i,
  input logic              q_ok_i,
  input logic              sync_flag_i,
  input logic              play_i,
  input logic              sel_digital_o,
  input logic              wr_strobe_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              cfg_err_o,
  input logic [2:0]        state_o
);
  a_r2_access_to_analog: assert property (@(posedge clk) disable iff (!rst_n)
    access_start_i |=> (!sel_digital_o && state_o == 3'd1));

  a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |=> !wr_strobe_o);

  a_r4_engage_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_digital_o) |-> (wr_strobe_o && wr_addr_o == ADDR_W'(8'h4E)));

  a_r4_engage_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_digital_o) |-> $past(sync_flag_i));

  a_r6_vco_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |-> !(wr_data_o[6] && !wr_data_o[10]));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

  a_r7_play_fail_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_digital_o && play_i && q_valid_i && !q_ok_i) |=> !sel_digital_o);

  a_r10_select_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
    sel_digital_o == (state_o == 3'd5));
endmodule

bind pll_switch_seq pll_switch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .access_start_i(access_start_i),
  .q_valid_i(q_valid_i), .q_ok_i(q_ok_i), .sync_flag_i(sync_flag_i),
  .play_i(play_i), .sel_digital_o(sel_digital_o), .wr_strobe_o(wr_strobe_o),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .cfg_err_o(cfg_err_o),
  .state_o(state_o)
);

// File: tb/pll_switch_seq_tb.sv
module pll_switch_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic access_start = 0, kick = 0, q_valid = 0, q_ok = 0, access_end = 0;
  logic sync_flag = 0, play = 0, c_double = 0, c_fine = 0, c_vco = 0;
  logic [15:0] tmo = 16'd0;
  logic sel_digital, wr_strobe, cfg_err;
  logic [7:0] wr_addr;
  logic [15:0] wr_data;
  logic [2:0] state;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_switch_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .access_start_i(access_start), .kick_i(kick),
    .q_valid_i(q_valid), .q_ok_i(q_ok), .access_end_i(access_end),
    .sync_flag_i(sync_flag), .play_i(play),
    .cfg_double_i(c_double), .cfg_fine_i(c_fine), .cfg_fast_vco_i(c_vco),
    .sync_timeout_i(tmo),
    .sel_digital_o(sel_digital), .wr_strobe_o(wr_strobe),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .cfg_err_o(cfg_err), .state_o(state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_access();
    access_start = 1; step(); access_start = 0;
  endtask
  task automatic do_kick();
    kick = 1; step(); kick = 0;
  endtask
  task automatic do_q(input logic ok);
    q_valid = 1; q_ok = ok; step(); q_valid = 0; q_ok = 0;
  endtask
  task automatic do_end();
    access_end = 1; step(); access_end = 0;
  endtask
  task automatic do_sync();
    sync_flag = 1; step(); sync_flag = 0;
  endtask
  task automatic to_wait_sync();
    do_access(); do_kick(); do_q(1'b1); do_end();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit err_exp;
    int n;
    err_exp = 0;
    step(); step();
    // R1 reset state
    chk("R1 state", state, 0);
    chk("R1 sel", sel_digital, 0);
    chk("R1 strobe", wr_strobe, 0);
    chk("R1 err", cfg_err, 0);
    rst_n = 1;
    step();

    // R3: events in idle are ignored
    do_kick(); chk("R3 kick in idle", state, 0);
    do_sync(); chk("R3 sync in idle", state, 0);

    // R5 / R6 sweep over all configurations
    for (int c = 0; c < 8; c++) begin
      logic [15:0] exp_w;
      c_double = c[0]; c_fine = c[1]; c_vco = c[2];
      if (c_vco && !c_double) err_exp = 1;
      exp_w = 16'((c[0] ? 1 << 10 : 0) | (c[1] ? 1 << 7 : 0) | ((c[2] && c[0]) ? 1 << 6 : 0));
      to_wait_sync();
      chk("R10 await sync code", state, 4);
      chk("R3 analog before sync", sel_digital, 0);
      do_sync();
      chk("R4 strobe", wr_strobe, 1);
      chk("R4 sel", sel_digital, 1);
      chk("R4 addr", wr_addr, 8'h4E);
      chk("R5 R6 word", wr_data, exp_w);
      chk("R6 err", cfg_err, err_exp);
      step();
      chk("R4 strobe one cycle", wr_strobe, 0);
      chk("R4 still digital", sel_digital, 1);
    end
    c_double = 0; c_fine = 0; c_vco = 0;

    // R3 order: out-of-order events ignored
    do_access(); chk("R2 to await kick", state, 1);
    do_sync(); chk("R3 sync before kick", state, 1);
    do_q(1'b1); chk("R3 read before kick", state, 1);
    do_kick(); chk("R3 kick", state, 2);
    do_end(); chk("R3 end before read", state, 2);
    do_sync(); chk("R3 sync before read", state, 2);
    do_q(1'b0); chk("R7 fail in await read", state, 1);
    do_kick(); do_q(1'b1); chk("R3 good read", state, 3);
    do_sync(); chk("R3 sync before end", state, 3);
    do_kick(); chk("R8 kick in await end", state, 2);
    do_q(1'b1); do_end(); chk("R3 end", state, 4);
    do_kick(); chk("R8 kick in await sync", state, 2);

    // R7 failed read in digital
    to_wait_sync(); do_sync();
    play = 0; do_q(1'b0);
    chk("R7 fail ignored without play", sel_digital, 1);
    chk("R7 state without play", state, 5);
    play = 1; do_q(1'b1);
    chk("R7 good read keeps digital", state, 5);
    do_q(1'b0);
    chk("R7 fail in play", state, 1);
    chk("R7 analog after fail", sel_digital, 0);

    // R8 kick in digital needs a new good read
    to_wait_sync(); do_sync();
    do_kick();
    chk("R8 kick in digital", state, 2);
    chk("R8 analog after kick", sel_digital, 0);
    do_sync(); chk("R8 no engage before read", sel_digital, 0);
    do_q(1'b1); do_end(); do_sync();
    chk("R8 re-engage", sel_digital, 1);
    play = 0;

    // R2 access from digital, and priority over sync
    do_access();
    chk("R2 access from digital", state, 1);
    chk("R2 analog", sel_digital, 0);
    to_wait_sync();
    sync_flag = 1; access_start = 1; step(); sync_flag = 0; access_start = 0;
    chk("R2 priority over sync", state, 1);
    chk("R2 no strobe", wr_strobe, 0);

    // R9 timeout sweep
    for (int t = 1; t <= 6; t++) begin
      tmo = 16'(t);
      to_wait_sync();
      n = 0;
      while (state == 3'd4 && n < 100) begin
        n++; step();
      end
      chk("R9 cycles in await sync", n, t);
      chk("R9 back to await kick", state, 1);
      chk("R9 analog", sel_digital, 0);
    end
    tmo = 0;
    to_wait_sync();
    repeat (60) step();
    chk("R9 zero disables", state, 4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule